// File: doc/BRIEF.md
# Qualified-Select Slave Front End with Word Register Bank

This block is the address-phase front end of a pipelined bus slave, attached here to a small bank of word registers. On every clock edge where the bus-wide ready input is high, it captures the slave select, address, direction, transfer type and size. It then decides whether the cycle is a real transfer aimed at this slave. The result, together with the direction and the word index, is held in a data-phase register.

In the following cycle, the data phase, the block carries out the access. A write stores the write-data bus into the indexed word. A read places that word on the read-data bus. The block never stalls and never reports an error. Idle and busy cycles, transfers that are not full-word, and cycles where the slave is not selected all finish with a zero-wait OKAY. They leave the bank untouched and return zero read data.

Top module: `ahbq_slave_front`

## Requirements
- R1: An address phase is qualified only when ready_i is 1, sel_i is 1, trans_i is NONSEQ (2'b10) or SEQ (2'b11), and size_i is word (3'b010). Only a qualified phase makes the next cycle perform a read or write.
- R2: A selected address phase with trans_i IDLE (2'b00) changes no register. In the next cycle readyout_o is 1, resp_o is OKAY (1'b0) and rdata_o is zero.
- R3: A selected address phase with trans_i BUSY (2'b01) makes no access and returns a zero-wait OKAY. A following SEQ phase is acted on normally.
- R4: In the cycle after a qualified write address phase, wdata_i is stored into the word indexed by addr_i[3:2]. The stored value is visible to any later read.
- R5: In the cycle after a qualified read address phase, rdata_o equals the word indexed by addr_i[3:2], including a word written in the immediately preceding data phase.
- R6: While ready_i is 0, the address-phase inputs are not sampled and the data-phase state is held.
- R7: An otherwise qualifying phase whose size_i is not 3'b010 causes no access.
- R8: rdata_o is zero in every cycle that is not the data phase of a qualified read.
- R9: Reset (rst_ni low) clears all words to zero and clears the data-phase select. During and after reset, readyout_o is 1 and resp_o is OKAY.
- R10: An address phase with sel_i low causes no access, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| sel_i | input | 1 | Slave select from the address decoder |
| addr_i | input | ADDR_W | Address; bits [3:2] pick the word |
| write_i | input | 1 | 1 = write, 0 = read |
| trans_i | input | 2 | Transfer type (IDLE, BUSY, NONSEQ, SEQ) |
| size_i | input | 3 | Transfer size; only 3'b010 is acted on |
| ready_i | input | 1 | Bus-wide ready; address phase valid when 1 |
| wdata_i | input | DATA_W | Write data, valid in the data phase |
| rdata_o | output | DATA_W | Read data in the data phase |
| readyout_o | output | 1 | Slave ready, always 1 |
| resp_o | output | 1 | Response, always OKAY (0) |

## Verification
A stray write from a wrongly qualified idle, busy, sub-word or unselected phase corrupts a word without any immediate sign at the ports. It shows up only on the next read of that word, which may be many cycles later. For that reason, every word is read back after each directed corner case. A data-phase register that fails to clear or to hold shows up within one cycle: rdata_o becomes non-zero where zero is required, or the wrong word appears.

// File: rtl/ahbq_pkg.sv
package ahbq_pkg;
    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    localparam logic [2:0] SZ_WORD  = 3'b010;
    localparam logic       RSP_OKAY = 1'b0;
endpackage

// File: rtl/ahbq_qualify.sv
module ahbq_qualify
    import ahbq_pkg::*;
(
    input  logic       sel_i,
    input  logic [1:0] trans_i,
    input  logic [2:0] size_i,
    input  logic       ready_i,
    output logic       take_o
);
    trans_e tr;
    logic   real_xfer;

    always_comb begin
        tr        = trans_e'(trans_i);
        real_xfer = (tr == TR_NONSEQ) || (tr == TR_SEQ);
        take_o    = ready_i && sel_i && real_xfer && (size_i == SZ_WORD);
    end
endmodule

// File: rtl/ahbq_regbank.sv
module ahbq_regbank #(
    parameter int DATA_W = 32,
    parameter int NWORDS = 4,
    localparam int IW    = $clog2(NWORDS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [IW-1:0]     widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IW-1:0]     ridx_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] word_d [NWORDS];
    logic [DATA_W-1:0] word_q [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_comb begin
            word_d[g] = word_q[g];
            if (we_i && (widx_i == IW'(g)))
                word_d[g] = wdata_i;
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) word_q[g] <= '0;
            else         word_q[g] <= word_d[g];
        end
    end

    assign rdata_o = word_q[ridx_i];
endmodule

// File: rtl/ahbq_slave_front.sv
module ahbq_slave_front
    import ahbq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int NWORDS = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              write_i,
    input  logic [1:0]        trans_i,
    input  logic [2:0]        size_i,
    input  logic              ready_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              readyout_o,
    output logic              resp_o
);
    localparam int IW      = $clog2(NWORDS);
    localparam int IDX_LSB = $clog2(DATA_W / 8);

    typedef struct packed {
        logic          act;
        logic          wr;
        logic [IW-1:0] idx;
    } dphase_t;

    dphase_t           ph_d, ph_q;
    logic              take;
    logic              commit;
    logic [DATA_W-1:0] bank_rd;
    logic              unused_addr_bits;

    assign unused_addr_bits = ^{addr_i[IDX_LSB-1:0], addr_i[ADDR_W-1:IDX_LSB+IW]};

    ahbq_qualify u_qual (
        .sel_i   (sel_i),
        .trans_i (trans_i),
        .size_i  (size_i),
        .ready_i (ready_i),
        .take_o  (take)
    );

    always_comb begin
        ph_d   = ph_q;
        commit = ph_q.act && ph_q.wr && ready_i;
        if (ready_i) begin
            ph_d.act = take;
            ph_d.wr  = write_i;
            ph_d.idx = addr_i[IDX_LSB +: IW];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ph_q <= '0;
        else         ph_q <= ph_d;
    end

    ahbq_regbank #(.DATA_W(DATA_W), .NWORDS(NWORDS)) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (commit),
        .widx_i  (ph_q.idx),
        .wdata_i (wdata_i),
        .ridx_i  (ph_q.idx),
        .rdata_o (bank_rd)
    );

    assign rdata_o    = (ph_q.act && !ph_q.wr) ? bank_rd : '0;
    assign readyout_o = 1'b1;
    assign resp_o     = RSP_OKAY;

    // R2
    idle_no_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_i && sel_i && trans_i == 2'b00) |=> !ph_q.act);

    // R3
    busy_no_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_i && sel_i && trans_i == 2'b01) |=> !ph_q.act);

    // R6
    stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ready_i |=> $stable(ph_q));

    // R7
    size_no_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_i && size_i != SZ_WORD) |=> !ph_q.act);

    // R10
    unsel_no_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_i && !sel_i) |=> !ph_q.act);

    // R4
    write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ph_q.act && ph_q.wr && ready_i) |=>
            (u_bank.word_q[$past(ph_q.idx)] == $past(wdata_i)));

    // R8
    rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ph_q.act && !ph_q.wr) |-> (rdata_o == '0));
endmodule

// File: tb/sim_ahbq_slave_front.sv
`timescale 1ns/1ps
module sim_ahbq_slave_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic [11:0] addr = '0;
    logic        wr = 1'b0;
    logic [1:0]  trans = 2'b00;
    logic [2:0]  size = 3'b010;
    logic        rdy = 1'b1;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        readyout;
    logic        resp;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] mem [4];
    logic        pa = 1'b0, pw = 1'b0;
    logic [1:0]  pi = '0;
    string       ptag = "R9";

    always #2.5 clk = ~clk;

    ahbq_slave_front u0 (
        .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .addr_i(addr),
        .write_i(wr), .trans_i(trans), .size_i(size), .ready_i(rdy),
        .wdata_i(wdata), .rdata_o(rdata), .readyout_o(readyout), .resp_o(resp)
    );

    function automatic logic qualifies(logic s, logic [1:0] t, logic [2:0] z);
        return s && t[1] && (z == 3'b010);
    endfunction

    function automatic logic [31:0] exp_rdata();
        return (pa && !pw) ? mem[pi] : 32'h0;
    endfunction

    task automatic check_out();
        logic [31:0] e;
        string       tg;
        e  = exp_rdata();
        tg = (pa && !pw) ? ptag : "R8";
        checks++;
        if (rdata !== e) begin
            fails++;
            $display("FAIL %s: rdata got %h expected %h", tg, rdata, e);
        end
        checks++;
        if (readyout !== 1'b1 || resp !== 1'b0) begin
            fails++;
            $display("FAIL R2: readyout/resp got %b/%b expected 1/0", readyout, resp);
        end
    endtask

    task automatic step(input string tag, input logic s, input logic [11:0] a,
                        input logic w, input logic [1:0] t, input logic [2:0] z,
                        input logic r, input logic [31:0] wd);
        check_out();
        sel = s; addr = a; wr = w; trans = t; size = z; rdy = r; wdata = wd;
        @(posedge clk);
        if (r) begin
            if (pa && pw) mem[pi] = wd;
            pa   = qualifies(s, t, z);
            pw   = w;
            pi   = a[3:2];
            ptag = tag;
        end
        @(negedge clk);
    endtask

    task automatic idle_step();
        step("R2", 1'b0, 12'h0, 1'b0, 2'b00, 3'b010, 1'b1, 32'hDEAD_0000);
    endtask

    task automatic read_all();
        for (int k = 0; k < 4; k++)
            step("R5", 1'b1, 12'(k * 4), 1'b0, 2'b10, 3'b010, 1'b1, 32'h0);
        idle_step();
    endtask

    initial begin
        for (int k = 0; k < 4; k++) mem[k] = '0;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        // R9: outputs while in reset
        check_out();
        rst_n = 1'b1;
        @(negedge clk);
        // R9: all words zero after reset
        read_all();

        // R4 / R2: write then IDLE at same address with stray data
        step("R4", 1'b1, 12'h004, 1'b1, 2'b10, 3'b010, 1'b1, 32'h0);
        step("R2", 1'b1, 12'h004, 1'b1, 2'b00, 3'b010, 1'b1, 32'hA5A5_1234);
        step("R5", 1'b1, 12'h004, 1'b0, 2'b10, 3'b010, 1'b1, 32'hFFFF_FFFF);
        // R3: BUSY then SEQ write to word 2
        step("R3", 1'b1, 12'h008, 1'b1, 2'b01, 3'b010, 1'b1, 32'h0);
        step("R3", 1'b1, 12'h008, 1'b1, 2'b11, 3'b010, 1'b1, 32'h1111_2222);
        step("R5", 1'b1, 12'h008, 1'b0, 2'b10, 3'b010, 1'b1, 32'h3333_4444);
        idle_step();
        read_all();

        // R7: halfword write is ignored
        step("R7", 1'b1, 12'h00C, 1'b1, 2'b10, 3'b001, 1'b1, 32'h0);
        step("R7", 1'b0, 12'h0, 1'b0, 2'b00, 3'b010, 1'b1, 32'hBAD0_0007);
        // R10: unselected write is ignored
        step("R10", 1'b0, 12'h000, 1'b1, 2'b10, 3'b010, 1'b1, 32'h0);
        step("R10", 1'b0, 12'h0, 1'b0, 2'b00, 3'b010, 1'b1, 32'hBAD0_0010);
        // R6: write request with ready low is not sampled
        step("R6", 1'b1, 12'h000, 1'b1, 2'b10, 3'b010, 1'b0, 32'h0);
        step("R6", 1'b0, 12'h0, 1'b0, 2'b00, 3'b010, 1'b1, 32'hBAD0_0006);
        // R1: IDLE with a read pending must not read
        step("R1", 1'b1, 12'h004, 1'b0, 2'b00, 3'b010, 1'b1, 32'h0);
        idle_step();
        read_all();

        // R1: constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic        s, w, r;
            logic [1:0]  t;
            logic [2:0]  z;
            s = ($urandom % 4) != 0;
            w = $urandom % 2;
            t = 2'($urandom % 4);
            z = (($urandom % 6) == 0) ? 3'($urandom % 8) : 3'b010;
            r = (pa && pw) ? 1'b1 : (($urandom % 8) != 0);
            step("R1", s, 12'($urandom), w, t, z, r, $urandom);
        end
        idle_step();
        read_all();
        check_out();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule